// File: doc/BRIEF.md
# EDO DRAM Output Drive Model

This block is a cycle-level, synthesizable model of the data-output behaviour of one extended-data-out DRAM bank. It samples the active-low row strobe, column strobe, write enable and output enable on each clock, together with a read-data word supplied from outside. From these it decides whether the bank drives its data lines, and which latched word it drives.

Unlike fast-page-mode output logic, a completed read keeps its word on the bus after the column strobe rises, for as long as the row strobe and output enable stay low. Output-enable and write-enable activity while the column strobe is high latches the outputs off until the next column cycle. Once both strobes are high, the outputs shut off a parameterised number of cycles later. The block is meant as a testbench-side responder or a reference model for a memory controller bench.

Top module: `edo_dq_ctrl`

## Requirements
- R1: After reset, dq_en_o is 0 and dq_o is all zeros.
- R2: A column-strobe falling edge seen with row strobe low and write enable high starts a read. It samples rd_data_i on the ACC_LAT-th clock edge after the capturing edge. From that edge on, dq_en_o is 1 while out_en_ni is low. Before that edge it is 0.
- R3: dq_o is all zeros whenever dq_en_o is 0. While both strobes are low, taking output enable high turns off the drive, and taking it low again drives the same word.
- R4: While driving, the word does not change. It stays driven after the column strobe rises while the row strobe and output enable stay low. A column strobe that rises during the access latency still lets the data become valid.
- R5: A change of output enable while the column strobe is high and the row strobe is low turns the drive off. The drive stays off until the next column-strobe falling edge.
- R6: A write-enable falling edge while the column strobe is high turns the drive off. It stays off until the next column-strobe falling edge.
- R7: A column-strobe falling edge with write enable low (early write) keeps the outputs off until the next column-strobe falling edge, whatever write enable does in between.
- R8: When the later of the two strobes rises so that both are high, an active drive continues for TOFF cycles, counting the edge that saw both high, and then stops regardless of output enable.
- R9: A column-strobe falling edge with the row strobe high (refresh) produces no drive.
- R10: If both strobes go high before the access latency ends, the read is aborted and nothing is driven.
- R11: A new column-strobe falling edge with write enable high re-arms the output from the off state and drives the newly sampled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_strobe_ni | input | 1 | Row address strobe, active low |
| col_strobe_ni | input | 1 | Column address strobe, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| out_en_ni | input | 1 | Output enable, active low |
| rd_data_i | input | DW | Word read from the external array |
| dq_en_o | output | 1 | Data lines driven |
| dq_o | output | DW | Driven word, zero when not driven |

## Verification
The bench sweeps a range of data words through full read cycles and counts the exact edge on which the drive appears and the number of cycles it lasts after both strobes are high. A model with the wrong latency or an off-by-one shutdown count fails on those edges. It separates an output-enable pulse with the column strobe low, which must restore the same word, from a toggle with the column strobe high, which must latch the drive off; a model that treats them alike either stays dark or comes back. Early write, a write-enable pulse with the column strobe high, refresh, and an access aborted by both strobes rising each hold the drive off. A new read must then re-arm it, which catches a model that never leaves the off state or that leaks stale data.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_VALID,
    ST_TURNOFF,
    ST_LOCKED
  } dq_state_e;
endpackage

// File: rtl/edo_pin_edges.sv
module edo_pin_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_strobe_ni,
  input  logic col_strobe_ni,
  input  logic wr_en_ni,
  input  logic out_en_ni,
  output logic col_fall_o,
  output logic both_rise_o,
  output logic wr_fall_o,
  output logic oe_chg_o,
  output logic col_hi_o
);
  logic row_q, col_q, wr_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= 1'b1;
      col_q <= 1'b1;
      wr_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      row_q <= row_strobe_ni;
      col_q <= col_strobe_ni;
      wr_q  <= wr_en_ni;
      oe_q  <= out_en_ni;
    end
  end

  assign col_fall_o  = col_q & ~col_strobe_ni;
  // later of the two strobe rises: both high now, not both high before
  assign both_rise_o = row_strobe_ni & col_strobe_ni & ~(row_q & col_q);
  assign wr_fall_o   = wr_q & ~wr_en_ni;
  assign oe_chg_o    = oe_q ^ out_en_ni;
  assign col_hi_o    = col_q & col_strobe_ni;
endmodule

// File: rtl/edo_dq_timer.sv
module edo_dq_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_timer_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_timer_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/edo_dq_fsm.sv
module edo_dq_fsm
  import edo_dq_pkg::*;
#(
  parameter int CW     = 4,
  parameter int ACC_LAT = 2,
  parameter int TOFF   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_strobe_ni,
  input  logic          wr_en_ni,
  input  logic          col_fall_i,
  input  logic          both_rise_i,
  input  logic          wr_fall_i,
  input  logic          oe_chg_i,
  input  logic          col_hi_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          data_load_o,
  output logic          drive_o
);
  localparam logic [CW-1:0] ACC_V = CW'(ACC_LAT - 1);
  localparam logic [CW-1:0] OFF_V = CW'(TOFF - 1);

  dq_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    data_load_o = 1'b0;
    if (col_fall_i) begin
      if (row_strobe_ni)  st_d = ST_IDLE;
      else if (!wr_en_ni) st_d = ST_LOCKED;
      else begin
        st_d       = ST_ACCESS;
        tmr_load_o = 1'b1;
        tmr_val_o  = ACC_V;
      end
    end else begin
      unique case (st_q)
        ST_ACCESS: begin
          if (both_rise_i) st_d = ST_IDLE;
          else if (tmr_zero_i) begin
            st_d        = ST_VALID;
            data_load_o = 1'b1;
          end
        end
        ST_VALID: begin
          if (both_rise_i) begin
            st_d       = ST_TURNOFF;
            tmr_load_o = 1'b1;
            tmr_val_o  = OFF_V;
          end else if (col_hi_i && (wr_fall_i || (oe_chg_i && !row_strobe_ni)))
            st_d = ST_LOCKED;
        end
        ST_TURNOFF: begin
          if (col_hi_i && wr_fall_i) st_d = ST_LOCKED;
          else if (tmr_zero_i)       st_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign drive_o = (st_q == ST_VALID) || (st_q == ST_TURNOFF);

  assert_wr_pulse_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_hi_i && wr_fall_i) |=> !drive_o);
  assert_locked_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_LOCKED) && !col_fall_i) |=> (st_q == ST_LOCKED));
  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_ACCESS) && both_rise_i && !col_fall_i) |=> !drive_o);
endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl #(
  parameter int DW      = 8,
  parameter int ACC_LAT = 2,
  parameter int TOFF    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          row_strobe_ni,
  input  logic          col_strobe_ni,
  input  logic          wr_en_ni,
  input  logic          out_en_ni,
  input  logic [DW-1:0] rd_data_i,
  output logic          dq_en_o,
  output logic [DW-1:0] dq_o
);
  localparam int MAXC = (ACC_LAT > TOFF) ? ACC_LAT : TOFF;
  localparam int CW   = $clog2(MAXC + 1);

  logic          col_fall, both_rise, wr_fall, oe_chg, col_hi;
  logic          tmr_load, tmr_zero, data_load, drive;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] data_q;

  edo_pin_edges u_edges (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_strobe_ni(row_strobe_ni),
    .col_strobe_ni(col_strobe_ni),
    .wr_en_ni     (wr_en_ni),
    .out_en_ni    (out_en_ni),
    .col_fall_o   (col_fall),
    .both_rise_o  (both_rise),
    .wr_fall_o    (wr_fall),
    .oe_chg_o     (oe_chg),
    .col_hi_o     (col_hi)
  );

  edo_dq_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  edo_dq_fsm #(.CW(CW), .ACC_LAT(ACC_LAT), .TOFF(TOFF)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_strobe_ni(row_strobe_ni),
    .wr_en_ni     (wr_en_ni),
    .col_fall_i   (col_fall),
    .both_rise_i  (both_rise),
    .wr_fall_i    (wr_fall),
    .oe_chg_i     (oe_chg),
    .col_hi_i     (col_hi),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .data_load_o  (data_load),
    .drive_o      (drive)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (data_load) data_q <= rd_data_i;
  end

  assign dq_en_o = drive & ~out_en_ni;
  assign dq_o    = dq_en_o ? data_q : '0;

  assert_read_hiz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_fall && wr_en_ni && !row_strobe_ni) |=> !dq_en_o);
  assert_early_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_fall && !wr_en_ni) |=> !dq_en_o);
  assert_refresh_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_fall && row_strobe_ni) |=> !dq_en_o);
  assert_word_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_en_o && $past(dq_en_o)) |-> $stable(dq_o));
endmodule

// File: tb/edo_dq_ctrl_tb.sv
module edo_dq_ctrl_tb;
  localparam int DW = 8, LAT = 2, TOFF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
  logic [DW-1:0] rd = '0;
  logic dq_en;
  logic [DW-1:0] dq;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  edo_dq_ctrl #(.DW(DW), .ACC_LAT(LAT), .TOFF(TOFF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .row_strobe_ni(ras), .col_strobe_ni(cas),
    .wr_en_ni(we), .out_en_ni(oe), .rd_data_i(rd), .dq_en_o(dq_en), .dq_o(dq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pins(input logic r, input logic c, input logic w, input logic o);
    ras = r; cas = c; we = w; oe = o;
  endtask

  task automatic chk(input string req, input logic en_x, input logic [DW-1:0] d_x);
    logic [DW-1:0] dx;
    dx = en_x ? d_x : '0;
    n_chk++;
    if (dq_en !== en_x || dq !== dx) begin
      n_fail++;
      $display("FAIL %s: en=%b dq=%h expected en=%b dq=%h", req, dq_en, dq, en_x, dx);
    end
  endtask

  // from idle with RAS high/CAS high: open row, start read, wait out latency
  task automatic do_read(input logic [DW-1:0] d, input string req);
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick();
    rd = d;
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk(req, 1'b0, d);
    for (int i = 1; i < LAT; i++) begin tick(); chk(req, 1'b0, d); end
    tick(); chk(req, 1'b1, d);
  endtask

  task automatic close_row();
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i <= TOFF + 1; i++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
    end
  end

  initial begin
    #1; chk("R1", 1'b0, '0);
    tick(); tick(); rst_n = 1'b1;
    tick(); chk("R1", 1'b0, '0);

    // R2/R8 sweep over data words with orderly row close
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] d;
      d = DW'(k * 17 + 3);
      do_read(d, "R2");
      pins(1'b0, 1'b1, 1'b1, 1'b0); tick(); chk("R4", 1'b1, d);
      pins(1'b1, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < TOFF; i++) begin tick(); chk("R8", 1'b1, d); end
      tick(); chk("R8", 1'b0, d);
      tick(); chk("R8", 1'b0, d);
      pins(1'b1, 1'b1, 1'b1, 1'b1); tick();
    end

    // R3: OE pulse with both strobes low restores the same word
    do_read(8'h5a, "R2");
    pins(1'b0, 1'b0, 1'b1, 1'b1); tick(); chk("R3", 1'b0, 8'h5a);
    rd = 8'hff;
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk("R3", 1'b1, 8'h5a);
    // R4: CAS high keeps data; R5: OE toggle then latches off
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick(); chk("R4", 1'b1, 8'h5a);
    tick(); chk("R4", 1'b1, 8'h5a);
    pins(1'b0, 1'b1, 1'b1, 1'b1); tick(); chk("R5", 1'b0, 8'h5a);
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick(); chk("R5", 1'b0, 8'h5a);
    tick(); chk("R5", 1'b0, 8'h5a);
    // R11: new read re-arms
    rd = 8'hc3;
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk("R11", 1'b0, 8'hc3);
    for (int i = 1; i < LAT; i++) begin tick(); chk("R11", 1'b0, 8'hc3); end
    tick(); chk("R11", 1'b1, 8'hc3);
    close_row();

    // R6: WE pulse with CAS high
    do_read(8'h81, "R2");
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick(); chk("R6", 1'b1, 8'h81);
    pins(1'b0, 1'b1, 1'b0, 1'b0); tick(); chk("R6", 1'b0, 8'h81);
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick(); chk("R6", 1'b0, 8'h81);
    tick(); chk("R6", 1'b0, 8'h81);
    close_row();

    // R7: early write holds off until next CAS cycle
    pins(1'b0, 1'b1, 1'b0, 1'b0); tick();
    rd = 8'h3c;
    pins(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < LAT + 2; i++) begin tick(); chk("R7", 1'b0, 8'h3c); end
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk("R7", 1'b0, 8'h3c);
    tick(); chk("R7", 1'b0, 8'h3c);
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick(); chk("R7", 1'b0, 8'h3c);
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk("R11", 1'b0, 8'h3c);
    for (int i = 1; i < LAT; i++) begin tick(); chk("R11", 1'b0, 8'h3c); end
    tick(); chk("R11", 1'b1, 8'h3c);
    close_row();

    // R9: CAS before RAS refresh
    rd = 8'h77;
    pins(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < LAT + 3; i++) begin tick(); chk("R9", 1'b0, 8'h77); end
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < LAT + 2; i++) begin tick(); chk("R9", 1'b0, 8'h77); end
    close_row();

    // R10: both strobes rise during access
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick();
    rd = 8'h99;
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk("R10", 1'b0, 8'h99);
    pins(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < LAT + TOFF + 2; i++) begin tick(); chk("R10", 1'b0, 8'h99); end

    // R4: CAS rises during latency, data still becomes valid
    pins(1'b0, 1'b1, 1'b1, 1'b0); tick();
    rd = 8'h42;
    pins(1'b0, 1'b0, 1'b1, 1'b0); tick(); chk("R4", 1'b0, 8'h42);
    pins(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 1; i < LAT; i++) begin tick(); chk("R4", 1'b0, 8'h42); end
    tick(); chk("R4", 1'b1, 8'h42);
    tick(); chk("R4", 1'b1, 8'h42);
    close_row(); chk("R8", 1'b0, 8'h42);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule